// File: doc/BRIEF.md
# UART interrupt status controller

This block collects the interrupt sources of a UART with receive and transmit FIFOs and turns them into interrupt lines. Two data-flow sources follow the FIFO fill levels: the receive source is active while the receive level is at or above its threshold, and the transmit source is active while the transmit level is at or below its threshold. When the FIFOs are switched off, each FIFO acts as a single slot. The receive source then tracks "slot full" and the transmit source tracks "slot empty". Four error strobes from the receiver, and change detection on four modem status lines, feed sticky status bits.

Every source has a raw status bit and a mask bit. Each interrupt output is the raw state gated by the mask. The receive and transmit outputs are kept apart from the error and modem outputs, so software can move data in response to FIFO levels alone. A small register port gives write access to the mask and to a write-one-to-clear register, and read access to the raw and masked status.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is held and on leaving it, all raw status bits and all mask bits are zero, so every interrupt output is low.
- R2: With FIFOs enabled, raw receive status (bit 4) is set in the cycle after the receive level becomes equal to or greater than the receive threshold. It drops in the cycle after the level falls below the threshold.
- R3: With FIFOs disabled, raw receive status is set one cycle after the receive level is nonzero and drops one cycle after it returns to zero.
- R4: With FIFOs enabled, raw transmit status (bit 5) is set one cycle after the transmit level is equal to or less than the transmit threshold. It drops one cycle after the level rises above it.
- R5: With FIFOs disabled, raw transmit status is set one cycle after the transmit level is zero and drops one cycle after it becomes nonzero.
- R6: A receive or transmit status cleared by software while its level condition still holds stays low. It sets again only after the condition has gone false and then true again.
- R7: A pulse on error strobe k (k = 0..3) sets raw bit 6+k on the next clock edge. The bit stays set until software clears it.
- R8: A level change on modem line k (bit 0 CTS, 1 DCD, 2 DSR, 3 RI) sets raw bit k on the third clock edge after the change, via a two-flop synchronizer. The modem output is the OR of the four masked change bits.
- R9: Writing the clear register (address 1) clears exactly the raw bits written as 1. Bits written as 0 are left alone, including modem bits that were not named.
- R10: Address 0 holds the mask, address 2 reads raw status and address 3 reads raw AND mask. Each interrupt output is its raw bits gated by their mask bits, and the combined output is the OR of all masked bits.
- R11: When an error strobe and a clear of the same bit occur in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1: FIFOs enabled, 0: single-slot mode |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_trig_i | input | LVL_W | Receive threshold |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| tx_trig_i | input | LVL_W | Transmit threshold |
| rx_err_i | input | 4 | Receive error strobes, one cycle per event |
| modem_i | input | 4 | Modem status lines: CTS, DCD, DSR, RI (bit 0 to 3) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | 0 mask, 1 clear, 2 raw, 3 masked |
| reg_wdata_i | input | 10 | Write data |
| reg_rdata_o | output | 10 | Read data for reg_addr_i (the clear address reads zero) |
| irq_rx_o | output | 1 | Masked receive interrupt |
| irq_tx_o | output | 1 | Masked transmit interrupt |
| irq_err_o | output | 1 | OR of masked error bits |
| irq_ms_o | output | 1 | OR of masked modem change bits |
| irq_o | output | 1 | OR of all masked bits |

## Verification
A wrong previous-condition flop in a level source shows up within one cycle, either as a receive or transmit interrupt coming back right after a clear or as one missing after a fresh crossing of the threshold. A broken synchronizer stage or a stale previous-sample flop on a modem line moves the change bit off its third-edge slot, or produces a change bit with no input activity. Mask and sticky register faults are visible right away in the masked read and on the per-source outputs. The bench therefore samples every output in the exact cycle that the requirements predict.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_MODEM = 4;
  localparam int unsigned NUM_ERR   = 4;
  localparam int unsigned MS_LSB    = 0;
  localparam int unsigned RX_BIT    = NUM_MODEM;
  localparam int unsigned TX_BIT    = NUM_MODEM + 1;
  localparam int unsigned ERR_LSB   = NUM_MODEM + 2;
  localparam int unsigned NUM_SRC   = NUM_MODEM + NUM_ERR + 2;
  localparam int unsigned SYNC_LEN  = 3;

  typedef enum logic [1:0] {
    ADDR_MASK   = 2'd0,
    ADDR_CLEAR  = 2'd1,
    ADDR_RAW    = 2'd2,
    ADDR_MASKED = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/uart_irq_modem_sync.sv
module uart_irq_modem_sync #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] chg_o
);
  import uart_irq_pkg::*;

  // compare starts only once the sync chain and the previous sample hold real values
  logic [SYNC_LEN-1:0] prime_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prime_q <= '0;
    else         prime_q <= {prime_q[SYNC_LEN-2:0], 1'b1};
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= line_i[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign chg_o[i] = prime_q[SYNC_LEN-1] & (s2_q ^ prev_q);
  end
endmodule

// File: rtl/uart_irq_level_src.sv
module uart_irq_level_src #(
  parameter int unsigned LVL_W = 5,
  parameter bit          IS_TX = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] trig_i,
  input  logic             clr_i,
  output logic             raw_o
);
  logic cond, cond_q, raw_q;

  if (IS_TX) begin : g_tx
    always_comb cond = fifo_en_i ? (level_i <= trig_i) : (level_i == '0);
  end else begin : g_rx
    always_comb cond = fifo_en_i ? (level_i >= trig_i) : (level_i != '0);
  end

  // a fresh rise sets, a software clear holds it low until the next rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      cond_q <= cond;
      raw_q  <= cond & ((cond & ~cond_q) | (raw_q & ~clr_i));
    end
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/uart_irq_status_reg.sv
module uart_irq_status_reg #(
  parameter int unsigned N_STICKY = 8,
  parameter int unsigned N_MASK   = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_STICKY-1:0] set_i,
  input  logic [N_STICKY-1:0] clr_i,
  input  logic                mask_we_i,
  input  logic [N_MASK-1:0]   mask_d_i,
  output logic [N_STICKY-1:0] sticky_o,
  output logic [N_MASK-1:0]   mask_o
);
  logic [N_STICKY-1:0] sticky_q;
  logic [N_MASK-1:0]   mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= '0;
      mask_q   <= '0;
    end else begin
      sticky_q <= set_i | (sticky_q & ~clr_i);  // set wins
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign sticky_o = sticky_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int unsigned LVL_W = 5
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               fifo_en_i,
  input  logic [LVL_W-1:0]                   rx_level_i,
  input  logic [LVL_W-1:0]                   rx_trig_i,
  input  logic [LVL_W-1:0]                   tx_level_i,
  input  logic [LVL_W-1:0]                   tx_trig_i,
  input  logic [uart_irq_pkg::NUM_ERR-1:0]   rx_err_i,
  input  logic [uart_irq_pkg::NUM_MODEM-1:0] modem_i,
  input  logic                               reg_wr_i,
  input  logic [1:0]                         reg_addr_i,
  input  logic [uart_irq_pkg::NUM_SRC-1:0]   reg_wdata_i,
  output logic [uart_irq_pkg::NUM_SRC-1:0]   reg_rdata_o,
  output logic                               irq_rx_o,
  output logic                               irq_tx_o,
  output logic                               irq_err_o,
  output logic                               irq_ms_o,
  output logic                               irq_o
);
  import uart_irq_pkg::*;

  localparam int unsigned N_STICKY = NUM_MODEM + NUM_ERR;

  logic [NUM_SRC-1:0]   clr_vec, raw_vec, mask_vec, masked_vec;
  logic [NUM_MODEM-1:0] ms_chg;
  logic [N_STICKY-1:0]  sticky, sticky_set, sticky_clr;
  logic                 rx_raw, tx_raw, clr_wr, mask_wr;

  assign clr_wr  = reg_wr_i & (reg_addr_i == ADDR_CLEAR);
  assign mask_wr = reg_wr_i & (reg_addr_i == ADDR_MASK);
  assign clr_vec = clr_wr ? reg_wdata_i : '0;

  uart_irq_modem_sync #(.N(NUM_MODEM)) u_ms (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (modem_i),
    .chg_o  (ms_chg)
  );

  uart_irq_level_src #(.LVL_W(LVL_W), .IS_TX(1'b0)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en_i),
    .level_i   (rx_level_i),
    .trig_i    (rx_trig_i),
    .clr_i     (clr_vec[RX_BIT]),
    .raw_o     (rx_raw)
  );

  uart_irq_level_src #(.LVL_W(LVL_W), .IS_TX(1'b1)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en_i),
    .level_i   (tx_level_i),
    .trig_i    (tx_trig_i),
    .clr_i     (clr_vec[TX_BIT]),
    .raw_o     (tx_raw)
  );

  assign sticky_set = {rx_err_i, ms_chg};
  assign sticky_clr = {clr_vec[ERR_LSB +: NUM_ERR], clr_vec[MS_LSB +: NUM_MODEM]};

  uart_irq_status_reg #(.N_STICKY(N_STICKY), .N_MASK(NUM_SRC)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (sticky_set),
    .clr_i     (sticky_clr),
    .mask_we_i (mask_wr),
    .mask_d_i  (reg_wdata_i),
    .sticky_o  (sticky),
    .mask_o    (mask_vec)
  );

  assign raw_vec    = {sticky[N_STICKY-1 -: NUM_ERR], tx_raw, rx_raw, sticky[NUM_MODEM-1:0]};
  assign masked_vec = raw_vec & mask_vec;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_MASK:   reg_rdata_o = mask_vec;
      ADDR_RAW:    reg_rdata_o = raw_vec;
      ADDR_MASKED: reg_rdata_o = masked_vec;
      default:     reg_rdata_o = '0;
    endcase
  end

  assign irq_rx_o  = raw_vec[RX_BIT] & mask_vec[RX_BIT];
  assign irq_tx_o  = raw_vec[TX_BIT] & mask_vec[TX_BIT];
  assign irq_err_o = |(raw_vec[ERR_LSB +: NUM_ERR] & mask_vec[ERR_LSB +: NUM_ERR]);
  assign irq_ms_o  = |(raw_vec[MS_LSB +: NUM_MODEM] & mask_vec[MS_LSB +: NUM_MODEM]);
  assign irq_o     = |masked_vec;
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int unsigned LVL_W = 5
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               fifo_en_i,
  input logic [LVL_W-1:0]                   rx_level_i,
  input logic [LVL_W-1:0]                   rx_trig_i,
  input logic [LVL_W-1:0]                   tx_level_i,
  input logic [LVL_W-1:0]                   tx_trig_i,
  input logic [uart_irq_pkg::NUM_ERR-1:0]   rx_err_i,
  input logic                               reg_wr_i,
  input logic [1:0]                         reg_addr_i,
  input logic [uart_irq_pkg::NUM_SRC-1:0]   reg_wdata_i,
  input logic [uart_irq_pkg::NUM_SRC-1:0]   raw_vec,
  input logic                               irq_rx_o,
  input logic                               irq_tx_o,
  input logic                               irq_err_o,
  input logic                               irq_ms_o,
  input logic                               irq_o
);
  import uart_irq_pkg::*;

  logic clr_wr;
  assign clr_wr = reg_wr_i && (reg_addr_i == ADDR_CLEAR);

  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !irq_o && !irq_rx_o && !irq_tx_o && !irq_err_o && !irq_ms_o);

  a_r2_rx_below_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && rx_level_i < rx_trig_i) |=> !raw_vec[RX_BIT]);

  a_r4_tx_above_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && tx_level_i > tx_trig_i) |=> !raw_vec[TX_BIT]);

  a_r6_rx_clear_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && reg_wdata_i[RX_BIT] && raw_vec[RX_BIT]) |=> !raw_vec[RX_BIT]);

  a_r7_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_err_i) |=> ((raw_vec[ERR_LSB +: NUM_ERR] & $past(rx_err_i)) == $past(rx_err_i)));

  a_r9_err_kept_without_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr |=> ((raw_vec[ERR_LSB +: NUM_ERR] & $past(raw_vec[ERR_LSB +: NUM_ERR]))
                 == $past(raw_vec[ERR_LSB +: NUM_ERR])));

  a_r10_combined_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (irq_rx_o || irq_tx_o || irq_err_o || irq_ms_o));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_en_i   (fifo_en_i),
  .rx_level_i  (rx_level_i),
  .rx_trig_i   (rx_trig_i),
  .tx_level_i  (tx_level_i),
  .tx_trig_i   (tx_trig_i),
  .rx_err_i    (rx_err_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .raw_vec     (raw_vec),
  .irq_rx_o    (irq_rx_o),
  .irq_tx_o    (irq_tx_o),
  .irq_err_o   (irq_err_o),
  .irq_ms_o    (irq_ms_o),
  .irq_o       (irq_o)
);

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;
  localparam int unsigned LVL_W = 5;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             fifo_en_i;
  logic [LVL_W-1:0] rx_level_i, rx_trig_i, tx_level_i, tx_trig_i;
  logic [3:0]       rx_err_i, modem_i;
  logic             reg_wr_i;
  logic [1:0]       reg_addr_i;
  logic [9:0]       reg_wdata_i, reg_rdata_o;
  logic             irq_rx_o, irq_tx_o, irq_err_o, irq_ms_o, irq_o;

  always #2 clk = ~clk;

  uart_irq_ctrl #(.LVL_W(LVL_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en_i),
    .rx_level_i(rx_level_i), .rx_trig_i(rx_trig_i),
    .tx_level_i(tx_level_i), .tx_trig_i(tx_trig_i),
    .rx_err_i(rx_err_i), .modem_i(modem_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_rx_o(irq_rx_o), .irq_tx_o(irq_tx_o),
    .irq_err_o(irq_err_o), .irq_ms_o(irq_ms_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // scoreboard: {irq_o, irq_ms, irq_err, irq_tx, irq_rx, rdata}
  string       tag_q[$];
  logic [14:0] exp_q[$];

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      string       t;
      logic [14:0] e, a;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      a = {irq_o, irq_ms_o, irq_err_o, irq_tx_o, irq_rx_o, reg_rdata_o};
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: irq=%b rdata=%h expected irq=%b rdata=%h",
                 t, a[14:10], a[9:0], e[14:10], e[9:0]);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick(1);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic expect_st(input string t, input logic [1:0] a,
                           input logic [9:0] rd, input logic [4:0] irq);
    reg_addr_i = a;
    tag_q.push_back(t);
    exp_q.push_back({irq, rd});
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; fifo_en_i = 1'b0;
    rx_level_i = '0; rx_trig_i = '0; tx_level_i = '0; tx_trig_i = '0;
    rx_err_i = '0; modem_i = '0;
    reg_wr_i = 1'b0; reg_addr_i = 2'd2; reg_wdata_i = '0;
    tick(2);
    expect_st("R1 raw in reset", 2'd2, 10'h000, 5'b00000);
    expect_st("R1 mask in reset", 2'd0, 10'h000, 5'b00000);
    rst_ni = 1'b1;
    tick(1);
    // single-slot mode, empty tx slot
    expect_st("R5 tx empty sets raw, masked off (R1)", 2'd2, 10'h020, 5'b00000);
    wr(2'd0, 10'h3FF);
    expect_st("R10 mask readback", 2'd0, 10'h3FF, 5'b10010);
    expect_st("R10 masked read", 2'd3, 10'h020, 5'b10010);
    tx_level_i = 5'd1; tick(1);
    expect_st("R5 tx slot filled", 2'd2, 10'h000, 5'b00000);
    rx_level_i = 5'd1; tick(1);
    expect_st("R3 rx slot filled", 2'd2, 10'h010, 5'b10001);
    rx_level_i = 5'd0; tick(1);
    expect_st("R3 rx slot read", 2'd2, 10'h000, 5'b00000);
    // FIFO mode
    fifo_en_i = 1'b1; rx_trig_i = 5'd4; tx_trig_i = 5'd2;
    tx_level_i = 5'd8; rx_level_i = 5'd3; tick(1);
    expect_st("R2 rx below threshold", 2'd2, 10'h000, 5'b00000);
    rx_level_i = 5'd4; tick(1);
    expect_st("R2 rx at threshold", 2'd2, 10'h010, 5'b10001);
    rx_level_i = 5'd5; tick(1);
    expect_st("R2 rx above threshold", 2'd2, 10'h010, 5'b10001);
    rx_level_i = 5'd3; tick(1);
    expect_st("R2 rx drops below", 2'd2, 10'h000, 5'b00000);
    tx_level_i = 5'd2; tick(1);
    expect_st("R4 tx at threshold", 2'd2, 10'h020, 5'b10010);
    tx_level_i = 5'd3; tick(1);
    expect_st("R4 tx above threshold", 2'd2, 10'h000, 5'b00000);
    // clear while condition holds
    rx_level_i = 5'd6; tick(1);
    expect_st("R6 rx set before clear", 2'd2, 10'h010, 5'b10001);
    wr(2'd1, 10'h010);
    expect_st("R6 rx cleared", 2'd2, 10'h000, 5'b00000);
    tick(2);
    expect_st("R6 no retrigger while held", 2'd2, 10'h000, 5'b00000);
    rx_level_i = 5'd2; tick(1);
    rx_level_i = 5'd4; tick(1);
    expect_st("R6 retrigger after fresh crossing", 2'd2, 10'h010, 5'b10001);
    wr(2'd1, 10'h010);
    rx_level_i = 5'd0; tick(1);
    // error strobes: bit 6+k
    rx_err_i = 4'b0010; tick(1);
    rx_err_i = 4'b0000;
    expect_st("R7 error bit set", 2'd2, 10'h080, 5'b10100);
    tick(3);
    expect_st("R7 error bit sticky", 2'd2, 10'h080, 5'b10100);
    rx_err_i = 4'b1000; tick(1);
    rx_err_i = 4'b0000;
    expect_st("R7 second error bit", 2'd2, 10'h280, 5'b10100);
    wr(2'd1, 10'h000);
    expect_st("R9 zero write no effect", 2'd2, 10'h280, 5'b10100);
    wr(2'd1, 10'h080);
    expect_st("R9 clears named bit only", 2'd2, 10'h200, 5'b10100);
    wr(2'd1, 10'h200);
    expect_st("R9 error cleared", 2'd2, 10'h000, 5'b00000);
    // modem lines
    modem_i = 4'b0101; tick(2);
    expect_st("R8 no change bit before third edge", 2'd2, 10'h000, 5'b00000);
    tick(1);
    expect_st("R8 change bits on third edge", 2'd2, 10'h005, 5'b11000);
    wr(2'd1, 10'h001);
    expect_st("R9 partial modem clear", 2'd2, 10'h004, 5'b11000);
    modem_i = 4'b1101; tick(3);
    expect_st("R8 RI change", 2'd2, 10'h00C, 5'b11000);
    wr(2'd0, 10'h3F3);
    expect_st("R10 modem masked off", 2'd3, 10'h000, 5'b00000);
    expect_st("R10 raw kept under mask", 2'd2, 10'h00C, 5'b00000);
    wr(2'd0, 10'h004);
    expect_st("R10 single modem bit unmasked", 2'd3, 10'h004, 5'b11000);
    // set and clear of one bit in the same cycle
    wr(2'd0, 10'h3FF);
    rx_err_i = 4'b0001;
    wr(2'd1, 10'h040);
    rx_err_i = 4'b0000;
    expect_st("R11 set wins over clear", 2'd2, 10'h04C, 5'b11100);
    tick(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule